// File: doc/BRIEF.md
# Packed Integer Media ALU

This block performs one lane-wise integer operation on two 64-bit operands in each cycle that the input strobe is high. The operands are read either as eight unsigned 8-bit lanes or as four 16-bit lanes, depending on the operation. Lane i of a byte operation occupies bits [8i+7:8i], and lane i of a word operation occupies bits [16i+15:16i]. The available operations are:

- rounded averages on byte lanes or on word lanes
- signed maximum and minimum on word lanes
- unsigned maximum and minimum on byte lanes
- an unsigned 16x16 multiply that keeps the upper half of each product
- a pass-through of the first operand

The result is captured in a register. A small two-state machine drives the valid flag. It is in ST_IDLE when no result was produced in the previous cycle. It moves to ST_DONE on any cycle with the strobe high (transition IDLE->DONE, or DONE->DONE for back-to-back strobes). It returns to ST_IDLE on a cycle without the strobe (transition DONE->IDLE). While it stays in ST_IDLE, the strobe is low.

Top module: `pmalu_top`

## Requirements
- R1: While rst_n is low, and after it is released until the first strobe, res reads 0 and res_vld reads 0.
- R2: res_vld is 1 in exactly the cycle after a cycle with in_stb high, and 0 otherwise; back-to-back strobes keep it high.
- R3: In a cycle with in_stb low, res keeps its previous value whatever op, src_a and src_b do.
- R4: op 0 sets each byte lane of res to (a+b+1)>>1, using a 9-bit sum, so 0xFF with 0xFF gives 0xFF.
- R5: op 1 sets each word lane of res to (a+b+1)>>1, using a 17-bit sum, so 0xFFFF with 0xFFFF gives 0xFFFF.
- R6: op 2 sets each word lane to the larger of the two lanes, compared as signed 16-bit values (0x7FFF beats 0x8000).
- R7: op 3 sets each word lane to the smaller of the two lanes, compared as signed 16-bit values.
- R8: op 4 sets each byte lane to the larger of the two lanes, compared as unsigned 8-bit values.
- R9: op 5 sets each byte lane to the smaller of the two lanes, compared as unsigned 8-bit values.
- R10: op 6 sets each word lane to bits [31:16] of the unsigned product a*b (0xFFFF*0xFFFF gives 0xFFFE).
- R11: op 7 copies src_a to res unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_stb | input | 1 | Operation strobe; operands and op are sampled when high |
| op | input | 3 | Operation select, codes 0 to 7 |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| res | output | 64 | Registered result |
| res_vld | output | 1 | High in the cycle after a strobe |

## Verification
The properties assume that in_stb, op, src_a and src_b carry known values on every clock edge after reset. They also assume that in_stb is held low while rst_n is low, so that no operation is requested across the reset boundary. The stimulus meets these assumptions in three ways: it changes every input only on the falling clock edge, it holds the strobe at 0 during each reset pulse, and it drives every operand from a defined constant or a computed value.

// File: rtl/pmalu_pkg.sv
package pmalu_pkg;

    typedef enum logic [2:0] {
        OP_AVG_B   = 3'd0,
        OP_AVG_W   = 3'd1,
        OP_MAX_SW  = 3'd2,
        OP_MIN_SW  = 3'd3,
        OP_MAX_UB  = 3'd4,
        OP_MIN_UB  = 3'd5,
        OP_MULH_UW = 3'd6,
        OP_PASS_A  = 3'd7
    } pm_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_DONE = 1'b1
    } pm_state_e;

endpackage

// File: rtl/pmalu_byte_lanes.sv
module pmalu_byte_lanes #(
    parameter int NB = 8
) (
    input  logic [NB*8-1:0] a,
    input  logic [NB*8-1:0] b,
    output logic [NB*8-1:0] avg,
    output logic [NB*8-1:0] umax,
    output logic [NB*8-1:0] umin
);
    localparam int LW = 8;

    for (genvar i = 0; i < NB; i++) begin : g_lane
        logic [LW-1:0] x, y;
        logic          x_ge;
        assign x    = a[i*LW +: LW];
        assign y    = b[i*LW +: LW];
        assign x_ge = (x >= y);
        // 9-bit intermediate keeps the carry before halving
        assign avg[i*LW +: LW]  = LW'((9'(x) + 9'(y) + 9'd1) >> 1);
        assign umax[i*LW +: LW] = x_ge ? x : y;
        assign umin[i*LW +: LW] = x_ge ? y : x;
    end

endmodule

// File: rtl/pmalu_word_lanes.sv
module pmalu_word_lanes #(
    parameter int NW = 4
) (
    input  logic [NW*16-1:0] a,
    input  logic [NW*16-1:0] b,
    output logic [NW*16-1:0] avg,
    output logic [NW*16-1:0] smax,
    output logic [NW*16-1:0] smin,
    output logic [NW*16-1:0] mulh
);
    localparam int LW = 16;
    localparam int PW = 2 * LW;

    for (genvar i = 0; i < NW; i++) begin : g_lane
        logic [LW-1:0] x, y;
        logic          x_ge_s;
        assign x      = a[i*LW +: LW];
        assign y      = b[i*LW +: LW];
        assign x_ge_s = ($signed(x) >= $signed(y));
        // 17-bit intermediate keeps the carry before halving
        assign avg[i*LW +: LW]  = LW'((17'(x) + 17'(y) + 17'd1) >> 1);
        assign smax[i*LW +: LW] = x_ge_s ? x : y;
        assign smin[i*LW +: LW] = x_ge_s ? y : x;
        assign mulh[i*LW +: LW] = LW'((PW'(x) * PW'(y)) >> LW);
    end

endmodule

// File: rtl/pmalu_top.sv
module pmalu_top
    import pmalu_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_stb,
    input  logic [2:0]        op,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    output logic [DATA_W-1:0] res,
    output logic              res_vld
);
    localparam int NB = DATA_W / 8;
    localparam int NW = DATA_W / 16;

    logic [DATA_W-1:0] b_avg, b_max, b_min;
    logic [DATA_W-1:0] w_avg, w_max, w_min, w_mulh;
    logic [DATA_W-1:0] sel;
    pm_state_e         state, state_nxt;

    pmalu_byte_lanes #(.NB(NB)) u_bytes (
        .a    (src_a),
        .b    (src_b),
        .avg  (b_avg),
        .umax (b_max),
        .umin (b_min)
    );

    pmalu_word_lanes #(.NW(NW)) u_words (
        .a    (src_a),
        .b    (src_b),
        .avg  (w_avg),
        .smax (w_max),
        .smin (w_min),
        .mulh (w_mulh)
    );

    always_comb begin
        unique case (pm_op_e'(op))
            OP_AVG_B:   sel = b_avg;
            OP_AVG_W:   sel = w_avg;
            OP_MAX_SW:  sel = w_max;
            OP_MIN_SW:  sel = w_min;
            OP_MAX_UB:  sel = b_max;
            OP_MIN_UB:  sel = b_min;
            OP_MULH_UW: sel = w_mulh;
            OP_PASS_A:  sel = src_a;
        endcase
    end

    // Next-state logic
    always_comb begin
        unique case (state)
            ST_IDLE: state_nxt = in_stb ? ST_DONE : ST_IDLE;
            ST_DONE: state_nxt = in_stb ? ST_DONE : ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)      res <= '0;
        else if (in_stb) res <= sel;
    end

    assign res_vld = (state == ST_DONE);

endmodule

// File: rtl/pmalu_chk.sv
module pmalu_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_stb,
    input logic [2:0]        op,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [DATA_W-1:0] res,
    input logic              res_vld
);
    a_r2_vld_after_stb: assert property (@(posedge clk) disable iff (!rst_n)
        in_stb |=> res_vld);

    a_r2_no_vld_without_stb: assert property (@(posedge clk) disable iff (!rst_n)
        !in_stb |=> !res_vld);

    a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
        !in_stb |=> $stable(res));

    a_r11_pass_a: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && op == 3'd7) |=> (res == $past(src_a)));

    a_r8_ubyte_max_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && op == 3'd4) |=> (res[7:0] >= $past(src_a[7:0]) && res[7:0] >= $past(src_b[7:0])));

    a_r9_ubyte_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && op == 3'd5) |=> (res[7:0] <= $past(src_a[7:0]) && res[7:0] <= $past(src_b[7:0])));

    a_r6_sword_max_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && op == 3'd2) |=> ($signed(res[15:0]) >= $signed($past(src_a[15:0]))
                                    && $signed(res[15:0]) >= $signed($past(src_b[15:0]))));

    a_r7_sword_min_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (in_stb && op == 3'd3) |=> ($signed(res[15:0]) <= $signed($past(src_a[15:0]))
                                    && $signed(res[15:0]) <= $signed($past(src_b[15:0]))));

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (res == '0 && !res_vld));

endmodule

bind pmalu_top pmalu_chk #(.DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_stb  (in_stb),
    .op      (op),
    .src_a   (src_a),
    .src_b   (src_b),
    .res     (res),
    .res_vld (res_vld)
);

// File: tb/sim_pmalu_top.sv
module sim_pmalu_top;
    localparam int CLK_P = 10;
    localparam int NV    = 12;

    localparam logic [2:0] T_OP [NV] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5,
                                         3'd6, 3'd7, 3'd0, 3'd2, 3'd6, 3'd5};
    localparam logic [63:0] T_A [NV] = '{
        64'h0102_FFFF_0080_7F10, 64'hFFFF_0001_8000_1234,
        64'h8000_7FFF_FFFF_0005, 64'h8000_7FFF_FFFF_0005,
        64'h00FF_807F_0110_AA55, 64'h00FF_807F_0110_AA55,
        64'hFFFF_0002_8000_1234, 64'hDEAD_BEEF_0123_4567,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_FFFF_8001_7FFE,
        64'h0000_0001_FFFF_4000, 64'h0000_0000_FFFF_FFFF};
    localparam logic [63:0] T_B [NV] = '{
        64'h0201_FFFF_0081_0010, 64'hFFFF_0002_7FFF_4321,
        64'h7FFF_8000_0000_FFFB, 64'h7FFF_8000_0000_FFFB,
        64'hFF00_7F80_1001_55AA, 64'hFF00_7F80_1001_55AA,
        64'hFFFF_8000_0002_5678, 64'h1111_2222_3333_4444,
        64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_0000_8000_7FFF,
        64'hFFFF_FFFF_FFFF_0004, 64'hFFFF_FFFF_0000_0001};
    localparam string T_REQ [NV] = '{"R4", "R5", "R6", "R7", "R8", "R9",
                                     "R10", "R11", "R4", "R6", "R10", "R9"};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_stb = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] res;
    logic        res_vld;
    int          n_chk = 0;
    int          n_err = 0;

    pmalu_top u0 (
        .clk(clk), .rst_n(rst_n), .in_stb(in_stb), .op(op),
        .src_a(src_a), .src_b(src_b), .res(res), .res_vld(res_vld)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [63:0] model(input logic [2:0] o,
                                          input logic [63:0] a, input logic [63:0] b);
        logic [63:0] r;
        r = a;
        for (int i = 0; i < 8; i++) begin
            int ux;
            int uy;
            ux = int'(a[8*i +: 8]);
            uy = int'(b[8*i +: 8]);
            case (o)
                3'd0: r[8*i +: 8] = 8'((ux + uy + 1) / 2);
                3'd4: r[8*i +: 8] = 8'((ux > uy) ? ux : uy);
                3'd5: r[8*i +: 8] = 8'((ux < uy) ? ux : uy);
                default: ;
            endcase
        end
        for (int i = 0; i < 4; i++) begin
            int     ux;
            int     uy;
            int     sx;
            int     sy;
            longint p;
            ux = int'(a[16*i +: 16]);
            uy = int'(b[16*i +: 16]);
            sx = int'($signed(a[16*i +: 16]));
            sy = int'($signed(b[16*i +: 16]));
            p  = longint'(ux) * longint'(uy);
            case (o)
                3'd1: r[16*i +: 16] = 16'((ux + uy + 1) / 2);
                3'd2: r[16*i +: 16] = 16'((sx > sy) ? sx : sy);
                3'd3: r[16*i +: 16] = 16'((sx < sy) ? sx : sy);
                3'd6: r[16*i +: 16] = 16'(p >> 16);
                default: ;
            endcase
        end
        return r;
    endfunction

    task automatic chk64(input logic [63:0] act, input logic [63:0] exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk1(input logic act, input logic exp, input string req);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic apply(input logic [2:0] o, input logic [63:0] a,
                         input logic [63:0] b, input string req);
        @(negedge clk);
        in_stb = 1'b1; op = o; src_a = a; src_b = b;
        @(negedge clk);
        in_stb = 1'b0;
        chk64(res, model(o, a, b), req);
        chk1(res_vld, 1'b1, "R2 vld after strobe");
    endtask

    initial begin
        #(CLK_P * 100000);
        n_err++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [63:0] held;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk64(res, 64'h0, "R1 res in reset");
        chk1(res_vld, 1'b0, "R1 vld in reset");
        rst_n = 1'b1;
        @(negedge clk);
        chk64(res, 64'h0, "R1 res after release");
        chk1(res_vld, 1'b0, "R1 vld after release");

        for (int k = 0; k < NV; k++) apply(T_OP[k], T_A[k], T_B[k], T_REQ[k]);

        // R4 / R5 rounding up and no lost carry
        apply(3'd0, 64'h0000_0000_0000_FF01, 64'h0000_0000_0000_FF02, "R4 round/carry");
        chk64(res, 64'h0000_0000_0000_FF02, "R4 literal");
        apply(3'd1, 64'h0000_0000_FFFF_0001, 64'h0000_0000_FFFF_0002, "R5 round/carry");
        chk64(res, 64'h0000_0000_FFFF_0002, "R5 literal");
        // R6 signed compare, R10 full-scale product
        apply(3'd2, 64'h0000_0000_0000_8000, 64'h0000_0000_0000_7FFF, "R6 signed");
        chk64(res, 64'h0000_0000_0000_7FFF, "R6 literal");
        apply(3'd6, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_FFFF, "R10 max product");
        chk64(res, 64'h0000_0000_0000_FFFE, "R10 literal");

        // R3 and R2: no strobe, inputs change, result held, valid low
        held = res;
        op = 3'd7; src_a = 64'hA5A5_A5A5_A5A5_A5A5; src_b = 64'h1;
        @(negedge clk);
        chk1(res_vld, 1'b0, "R2 vld low without strobe");
        op = 3'd0; src_a = 64'h5A5A_5A5A_5A5A_5A5A;
        @(negedge clk);
        chk64(res, held, "R3 hold");

        // R2 back-to-back strobes
        @(negedge clk);
        in_stb = 1'b1; op = 3'd7; src_a = 64'h1111_2222_3333_4444;
        @(negedge clk);
        chk64(res, 64'h1111_2222_3333_4444, "R11 first of pair");
        chk1(res_vld, 1'b1, "R2 pair first");
        src_a = 64'h5555_6666_7777_8888;
        @(negedge clk);
        in_stb = 1'b0;
        chk64(res, 64'h5555_6666_7777_8888, "R11 second of pair");
        chk1(res_vld, 1'b1, "R2 pair second");
        @(negedge clk);
        chk1(res_vld, 1'b0, "R2 vld drops");

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk64(res, 64'h0, "R1 res mid-run reset");
        chk1(res_vld, 1'b0, "R1 vld mid-run reset");
        rst_n = 1'b1;
        @(negedge clk);

        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule